// File: doc/BRIEF.md
# Task-Event UART Register Controller

This block is the software-facing control plane of a small UART. Software starts and stops the two directions by writing "task" addresses, and watches progress through "event" registers that flag a received byte, a finished transmit, a line break and the end of reception. A single level interrupt is raised whenever an event is pending and its bit in the interrupt-enable register is set. The bit serializer, the deserializer and the baud generator sit outside the block. They connect through a transmit byte port, a receive byte port and a break-detect strobe.

The register bus is synchronous. A request is one cycle of `bus_valid`, with `bus_write`, a word-aligned byte address and write data. Read data is registered and appears on `bus_rdata` in the cycle after the request. It holds until the next read. Both byte ports are valid/ready streams. On the transmit side the block holds `tx_valid` and `tx_data` steady until the serializer asserts `tx_ready`, so the serializer applies back-pressure by keeping `tx_ready` low. On the receive side `rx_ready` is high exactly while reception is started. A byte offered while `rx_ready` is low is not taken, and the deserializer must keep it or drop it.

The peripheral starts disabled and must be unlocked by writing a key value to the enable register. The interrupt enable can be written whole, ORed with a mask, or cleared by a mask. Each of these three forms has its own address.

Top module: `evreg_uart_ctrl`

## Requirements
- R1: After reset, with the block enabled: the four pin-select registers (0x508, 0x50C, 0x510, 0x514) read 0xFFFFFFFF, the baud register (0x524) reads 0x04000000, and every other register, event and flag is zero. The pin-select and baud registers are read/write storage. Right after reset, `irq`, `tx_valid`, `rx_ready` and `bus_rdata` are 0.
- R2: Writing exactly 4 to the enable register (0x500) enables the block. Other nonzero values leave the state unchanged. Writing 0 disables the block and also acts as a suspend (R5).
- R3: While disabled, every read returns 0 and every write is ignored, except a write to 0x500.
- R4: Writing exactly 1 to start-RX (0x000) or start-TX (0x008) sets that direction's started flag. Any other value has no effect.
- R5: Writing 1 to the following task addresses has these effects. Stop-TX (0x00C) clears only the transmit flag. Stop-RX (0x004) clears the receive flag and sets the RX-timeout event (0x10C). Suspend (0x01C) clears both flags and sets the RX-timeout event.
- R6: A write to TXD (0x51C) is taken only while transmit is started and no byte is pending. A taken byte is presented as `tx_data` with `tx_valid` high. Both stay unchanged until `tx_ready` is seen. On that edge `tx_valid` drops and the TX-ready event (0x104) is set. TXD reads back the last byte taken.
- R7: The interrupt enable is reached at three addresses: 0x300 loads the written value, 0x304 ORs it in, and 0x308 clears the bits written as 1. A read at any of the three returns the current value.
- R8: `irq` is high when any event is nonzero and its enable bit is set. The enable bits are: bit 0 RX ready, bit 1 TX ready, bit 2 error, bit 3 RX timeout. `irq` follows register state in the cycle after the write that changed it.
- R9: The error-source register (0x400) clears the bits written as 1. A `brk_in` pulse ORs 3 into it and sets the error event (0x108). If a break and a clear fall in the same cycle, the break's bits survive.
- R10: When `rx_valid` and `rx_ready` are both high, the byte is latched into RXD (0x518) and the RX-ready event (0x100) is set. That event is cleared only by writing 0 to it. The TX, error and timeout events take the written value directly. Writes to RXD are ignored.
- R11: If the transmit handshake completes in the same cycle as a software write to the TX-ready event, the event ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_ready | output | 1 | Reception started, byte accepted |
| rx_data | input | 8 | Received byte |
| brk_in | input | 1 | Line break detected (one-cycle pulse) |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. In the first, the serializer's handshake and a software write of 0 to the TX-ready event arrive together. In the second, a break pulse and a write-one-to-clear of the error-source register arrive together. The bench provokes each pair by driving the bus write and the side input on the same clock edge. Afterwards it judges the outcome by reading the affected register and watching `irq`: the hardware set must win in both cases.

// File: rtl/evreg_pkg.sv
package evreg_pkg;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int BW  = 8;
  localparam int NEV = 4;

  // event indices, also the interrupt-enable bit positions
  localparam int EV_RX   = 0;
  localparam int EV_TX   = 1;
  localparam int EV_ERR  = 2;
  localparam int EV_RXTO = 3;

  localparam logic [AW-1:0] A_RX_GO   = 12'h000;
  localparam logic [AW-1:0] A_RX_HALT = 12'h004;
  localparam logic [AW-1:0] A_TX_GO   = 12'h008;
  localparam logic [AW-1:0] A_TX_HALT = 12'h00C;
  localparam logic [AW-1:0] A_PAUSE   = 12'h01C;
  localparam logic [AW-1:0] A_EV_RX   = 12'h100;
  localparam logic [AW-1:0] A_EV_TX   = 12'h104;
  localparam logic [AW-1:0] A_EV_ERR  = 12'h108;
  localparam logic [AW-1:0] A_EV_RXTO = 12'h10C;
  localparam logic [AW-1:0] A_IEN     = 12'h300;
  localparam logic [AW-1:0] A_IEN_SET = 12'h304;
  localparam logic [AW-1:0] A_IEN_CLR = 12'h308;
  localparam logic [AW-1:0] A_ERRSRC  = 12'h400;
  localparam logic [AW-1:0] A_ENABLE  = 12'h500;
  localparam logic [AW-1:0] A_PSEL0   = 12'h508;
  localparam logic [AW-1:0] A_RXD     = 12'h518;
  localparam logic [AW-1:0] A_TXD     = 12'h51C;
  localparam logic [AW-1:0] A_BAUD    = 12'h524;

  localparam int              NPSEL     = 4;
  localparam logic [DW-1:0]   ENABLE_KEY = 32'd4;
  localparam logic [DW-1:0]   BAUD_INIT  = 32'h0400_0000;
  localparam logic [DW-1:0]   BRK_BITS   = 32'd3;
endpackage

// File: rtl/evreg_run_ctl.sv
module evreg_run_ctl
  import evreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_enable,
  input  logic          wr_rx_go,
  input  logic          wr_rx_halt,
  input  logic          wr_tx_go,
  input  logic          wr_tx_halt,
  input  logic          wr_pause,
  input  logic [DW-1:0] wdata,
  output logic          enabled,
  output logic          tx_on,
  output logic          rx_on,
  output logic          rxto_set
);
  logic is_one, is_zero, halt_all, tx_clr, rx_clr;

  assign is_one   = (wdata == 32'd1);
  assign is_zero  = (wdata == '0);
  assign halt_all = (wr_pause && is_one) || (wr_enable && is_zero);
  assign tx_clr   = halt_all || (wr_tx_halt && is_one);
  assign rx_clr   = halt_all || (wr_rx_halt && is_one);
  assign rxto_set = rx_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      tx_on   <= 1'b0;
      rx_on   <= 1'b0;
    end else begin
      if (wr_enable) begin
        if (wdata == ENABLE_KEY) enabled <= 1'b1;
        else if (is_zero)        enabled <= 1'b0;
      end
      if (tx_clr)                  tx_on <= 1'b0;
      else if (wr_tx_go && is_one) tx_on <= 1'b1;
      if (rx_clr)                  rx_on <= 1'b0;
      else if (wr_rx_go && is_one) rx_on <= 1'b1;
    end
  end
endmodule

// File: rtl/evreg_tx_handoff.sv
module evreg_tx_handoff #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_byte,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_byte,
  output logic          done
);
  logic pend_q;

  assign out_valid = pend_q;
  assign done      = pend_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      out_byte <= '0;
    end else if (done) begin
      pend_q <= 1'b0;
    end else if (load && !pend_q) begin
      pend_q   <= 1'b1;
      out_byte <= load_byte;
    end
  end
endmodule

// File: rtl/evreg_irq_merge.sv
module evreg_irq_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] ev_hit,
  input  logic [N-1:0] ev_mask,
  output logic         irq
);
  logic [N-1:0] term;
  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = ev_hit[i] & ev_mask[i];
  end
  assign irq = |term;
endmodule

// File: rtl/evreg_uart_ctrl.sv
module evreg_uart_ctrl
  import evreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [BW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [BW-1:0] rx_data,
  input  logic          brk_in,
  output logic          irq
);
  logic          wr, acc, en_q, tx_on, rx_on, rxto_set, tx_done;
  logic          ev_rx_q;
  logic [DW-1:0] ev_tx_q, ev_err_q, ev_rxto_q, ien_q, errsrc_q, baud_q;
  logic [DW-1:0] psel_q [NPSEL];
  logic [BW-1:0] rxd_q;
  logic [DW-1:0] rmux;
  logic [NEV-1:0] hit;

  assign wr  = bus_valid && bus_write;
  assign acc = wr && en_q;
  assign rx_ready = rx_on;

  evreg_run_ctl u_run (
    .clk(clk), .rst_n(rst_n),
    .wr_enable (wr  && bus_addr == A_ENABLE),
    .wr_rx_go  (acc && bus_addr == A_RX_GO),
    .wr_rx_halt(acc && bus_addr == A_RX_HALT),
    .wr_tx_go  (acc && bus_addr == A_TX_GO),
    .wr_tx_halt(acc && bus_addr == A_TX_HALT),
    .wr_pause  (acc && bus_addr == A_PAUSE),
    .wdata(bus_wdata),
    .enabled(en_q), .tx_on(tx_on), .rx_on(rx_on), .rxto_set(rxto_set)
  );

  evreg_tx_handoff #(.BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(acc && bus_addr == A_TXD && tx_on),
    .load_byte(bus_wdata[BW-1:0]),
    .out_valid(tx_valid), .out_ready(tx_ready),
    .out_byte(tx_data), .done(tx_done)
  );

  assign hit[EV_RX]   = ev_rx_q;
  assign hit[EV_TX]   = (ev_tx_q   != '0);
  assign hit[EV_ERR]  = (ev_err_q  != '0);
  assign hit[EV_RXTO] = (ev_rxto_q != '0);

  evreg_irq_merge #(.N(NEV)) u_irq (
    .ev_hit(hit), .ev_mask(ien_q[NEV-1:0]), .irq(irq)
  );

  // events, interrupt enable, error source, plain storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_rx_q   <= 1'b0;
      ev_tx_q   <= '0;
      ev_err_q  <= '0;
      ev_rxto_q <= '0;
      ien_q     <= '0;
      errsrc_q  <= '0;
      baud_q    <= BAUD_INIT;
      rxd_q     <= '0;
      for (int i = 0; i < NPSEL; i++) psel_q[i] <= '1;
    end else begin
      if (rx_valid && rx_on) begin
        ev_rx_q <= 1'b1;
        rxd_q   <= rx_data;
      end else if (acc && bus_addr == A_EV_RX && bus_wdata == '0) begin
        ev_rx_q <= 1'b0;
      end
      // hardware sets take priority over software writes
      if (tx_done)                          ev_tx_q <= 32'd1;
      else if (acc && bus_addr == A_EV_TX)  ev_tx_q <= bus_wdata;
      if (brk_in)                           ev_err_q <= 32'd1;
      else if (acc && bus_addr == A_EV_ERR) ev_err_q <= bus_wdata;
      if (rxto_set)                          ev_rxto_q <= 32'd1;
      else if (acc && bus_addr == A_EV_RXTO) ev_rxto_q <= bus_wdata;
      if (acc && bus_addr == A_ERRSRC)
        errsrc_q <= (errsrc_q & ~bus_wdata) | (brk_in ? BRK_BITS : '0);
      else if (brk_in)
        errsrc_q <= errsrc_q | BRK_BITS;
      if (acc) begin
        case (bus_addr)
          A_IEN:     ien_q  <= bus_wdata;
          A_IEN_SET: ien_q  <= ien_q | bus_wdata;
          A_IEN_CLR: ien_q  <= ien_q & ~bus_wdata;
          A_BAUD:    baud_q <= bus_wdata;
          default: ;
        endcase
        for (int i = 0; i < NPSEL; i++)
          if (bus_addr == A_PSEL0 + AW'(4 * i)) psel_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_EV_RX:   rmux = {{(DW-1){1'b0}}, ev_rx_q};
      A_EV_TX:   rmux = ev_tx_q;
      A_EV_ERR:  rmux = ev_err_q;
      A_EV_RXTO: rmux = ev_rxto_q;
      A_IEN, A_IEN_SET, A_IEN_CLR: rmux = ien_q;
      A_ERRSRC:  rmux = errsrc_q;
      A_ENABLE:  rmux = ENABLE_KEY;
      A_RXD:     rmux = {{(DW-BW){1'b0}}, rxd_q};
      A_TXD:     rmux = {{(DW-BW){1'b0}}, tx_data};
      A_BAUD:    rmux = baud_q;
      default: ;
    endcase
    for (int i = 0; i < NPSEL; i++)
      if (bus_addr == A_PSEL0 + AW'(4 * i)) rmux = psel_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= en_q ? rmux : '0;
  end
endmodule

// File: rtl/evreg_uart_ctrl_chk.sv
module evreg_uart_ctrl_chk
  import evreg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [BW-1:0] tx_data,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          brk_in,
  input logic          en_q,
  input logic          ev_rx_q,
  input logic [DW-1:0] ev_err_q,
  input logic [DW-1:0] errsrc_q
);
  assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_drop_after_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid);

  assert_dark_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && !en_q |=> bus_rdata == '0);

  assert_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_in |=> errsrc_q[1:0] == 2'b11 && ev_err_q != '0);

  assert_rx_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> ev_rx_q);

  assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == A_ENABLE && bus_wdata == '0
    |=> !en_q && !rx_ready);
endmodule

bind evreg_uart_ctrl evreg_uart_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .brk_in(brk_in),
  .en_q(en_q), .ev_rx_q(ev_rx_q), .ev_err_q(ev_err_q), .errsrc_q(errsrc_q)
);

// File: tb/evreg_uart_ctrl_bench.sv
module evreg_uart_ctrl_bench;
  localparam logic [11:0] RX_GO = 12'h000, RX_HALT = 12'h004, TX_GO = 12'h008,
    TX_HALT = 12'h00C, PAUSE = 12'h01C, EVRX = 12'h100, EVTX = 12'h104,
    EVERR = 12'h108, EVTO = 12'h10C, IEN = 12'h300, IENS = 12'h304,
    IENC = 12'h308, ESRC = 12'h400, ENA = 12'h500, PS0 = 12'h508,
    PS3 = 12'h514, RXD = 12'h518, TXD = 12'h51C, BAUD = 12'h524;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, brk_in = 0, irq;
  logic [7:0] tx_data, rx_data = '0;
  int checks = 0, errors = 0;
  logic [31:0] tmp;

  always #10 clk = ~clk;

  evreg_uart_ctrl u_evreg_uart_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .brk_in(brk_in), .irq(irq));

  // {write, req, addr, data}: data is write value or expected read value
  localparam int NV = 22;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 4'd2,  ENA,  32'd5},          // R2 non-key value ignored
    {1'b0, 4'd2,  PS0,  32'd0},          // R2 still disabled
    {1'b1, 4'd2,  ENA,  32'd4},
    {1'b0, 4'd1,  PS0,  32'hFFFF_FFFF},  // R1
    {1'b0, 4'd1,  PS3,  32'hFFFF_FFFF},  // R1
    {1'b0, 4'd1,  BAUD, 32'h0400_0000},  // R1
    {1'b0, 4'd1,  ESRC, 32'd0},          // R1
    {1'b1, 4'd7,  IEN,  32'd5},
    {1'b0, 4'd7,  IENS, 32'd5},          // R7
    {1'b1, 4'd7,  IENS, 32'd2},
    {1'b0, 4'd7,  IENC, 32'd7},          // R7
    {1'b1, 4'd7,  IENC, 32'd5},
    {1'b0, 4'd7,  IEN,  32'd2},          // R7
    {1'b1, 4'd10, EVTX, 32'd9},
    {1'b0, 4'd10, EVTX, 32'd9},          // R10 direct value
    {1'b1, 4'd10, EVTX, 32'd0},
    {1'b1, 4'd10, RXD,  32'h55},
    {1'b0, 4'd10, RXD,  32'd0},          // R10 RXD write ignored
    {1'b1, 4'd10, EVRX, 32'd1},
    {1'b0, 4'd10, EVRX, 32'd0},          // R10 nonzero write no effect
    {1'b1, 4'd6,  TXD,  32'h41},
    {1'b0, 4'd6,  TXD,  32'd0}           // R6 TX not started
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_valid = 0;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the pins
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) wr(VEC[i][43:32], VEC[i][31:0]);
      else rdchk($sformatf("R%0d vec%0d", VEC[i][47:44], i), VEC[i][43:32], VEC[i][31:0]);
    end

    // R4 / R6 / R8: transmit path, IEN = TX bit only
    wr(TX_GO, 2);
    wr(TXD, 32'h41);
    chk("R4 start with 2 ignored", {31'b0, tx_valid}, 0);
    wr(TX_GO, 1);
    wr(TXD, 32'hA5);
    chk("R6 tx_valid", {31'b0, tx_valid}, 1);
    wr(TXD, 32'h11);
    chk("R6 byte held while pending", {24'b0, tx_data}, 32'hA5);
    chk("R8 no event yet", {31'b0, irq}, 0);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R6 tx_valid drops", {31'b0, tx_valid}, 0);
    chk("R8 irq from TX event", {31'b0, irq}, 1);
    rdchk("R6 TX event", EVTX, 1);
    rdchk("R6 TXD readback", TXD, 32'hA5);

    // R11: handshake and event clear in the same cycle
    wr(EVTX, 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    wr(TXD, 32'h22);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = EVTX; bus_wdata = 0; tx_ready = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; tx_ready = 0;
    rdchk("R11 handshake wins", EVTX, 1);
    chk("R11 irq held", {31'b0, irq}, 1);
    wr(EVTX, 0);

    // R10 receive path
    wr(IEN, 1);
    chk("R10 rx_ready before start", {31'b0, rx_ready}, 0);
    wr(RX_GO, 1);
    chk("R4 rx started", {31'b0, rx_ready}, 1);
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C;
    @(negedge clk); rx_valid = 0;
    chk("R8 irq from RX event", {31'b0, irq}, 1);
    rdchk("R10 RXD latched", RXD, 32'h3C);
    wr(EVRX, 0);
    chk("R10 RX event cleared by 0", {31'b0, irq}, 0);

    // R5 stop cascades
    wr(IEN, 8);
    wr(RX_HALT, 1);
    chk("R5 stop-RX clears rx", {31'b0, rx_ready}, 0);
    chk("R5 timeout irq", {31'b0, irq}, 1);
    rdchk("R5 timeout event", EVTO, 1);
    wr(EVTO, 0);
    wr(RX_GO, 1); wr(TX_GO, 1);
    wr(TX_HALT, 1);
    chk("R5 stop-TX keeps rx", {31'b0, rx_ready}, 1);
    rdchk("R5 stop-TX no timeout", EVTO, 0);
    wr(TXD, 32'h77);
    chk("R5 TXD after stop-TX ignored", {31'b0, tx_valid}, 0);
    wr(TX_GO, 1);
    wr(PAUSE, 1);
    chk("R5 suspend clears rx", {31'b0, rx_ready}, 0);
    wr(TXD, 32'h78);
    chk("R5 suspend clears tx", {31'b0, tx_valid}, 0);
    rdchk("R5 suspend timeout", EVTO, 1);
    wr(EVTO, 0);

    // R9 break and error source
    wr(IEN, 4);
    @(negedge clk); brk_in = 1;
    @(negedge clk); brk_in = 0;
    chk("R9 irq from break", {31'b0, irq}, 1);
    rdchk("R9 errsrc set", ESRC, 3);
    wr(ESRC, 1);
    rdchk("R9 w1c", ESRC, 2);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = ESRC; bus_wdata = 3; brk_in = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; brk_in = 0;
    rdchk("R9 break beats clear", ESRC, 3);
    wr(EVERR, 0);
    chk("R9 error event cleared", {31'b0, irq}, 0);

    // R2 / R3 disable
    wr(RX_GO, 1);
    wr(ENA, 0);
    chk("R2 disable stops rx", {31'b0, rx_ready}, 0);
    rdchk("R3 read while disabled", IEN, 0);
    wr(IEN, 32'hF);
    wr(RX_GO, 1);
    chk("R3 task ignored while disabled", {31'b0, rx_ready}, 0);
    wr(ENA, 4);
    rdchk("R3 IEN unchanged", IEN, 4);
    rdchk("R2 disable set timeout", EVTO, 1);
    // R1 storage registers write/read
    wr(BAUD, 32'h0100_0000);
    rdchk("R1 baud writable", BAUD, 32'h0100_0000);
    tmp = bus_rdata;
    wr(IEN, 0);
    chk("R1 rdata holds across write", bus_rdata, tmp);

    finish_run();
  end
endmodule